// File: doc/BRIEF.md
# Windowed Round-Robin Slave-Port Arbiter

This block sits in front of one slave port of a multilayer bus matrix and decides which of four masters may use it: the instruction-fetch port, the data/debug port on code space, the system port, and the DMA engine. Each master raises a request and presents an address and a write flag. A master is eligible only if its address lies inside the range that this master is allowed to reach. A request outside that range is never granted. It gets an error flag in the same cycle instead.

A transfer is an address phase of one cycle followed by a data phase. When the slave is free, the arbiter picks one eligible master by rotating priority. It drives that master's address, write flag and identity to the slave in the same cycle, so the arbitration itself costs no cycle. The data phase lasts until the slave raises ready. During that cycle the owner sees ready and every other master sees ready low. A different master's address phase may overlap the final data-phase cycle, so the port can carry a new transfer every cycle. After each completed transfer, the rotation pointer moves to the master after the one that just finished.

Master indices are fixed: 0 instruction fetch, 1 code data, 2 system, 3 DMA.

Top module: `bus_slave_rr_arb`

## Requirements
- R1: Masters 0 and 1 are eligible only for addresses 0x0000_0000 to 0x1FFF_FFFF.
- R2: Master 2 is eligible only for addresses 0x2000_0000 to 0xDFFF_FFFF.
- R3: Master 3 is eligible for addresses 0x0000_0000 to 0xDFFF_FFFF, except the code-space SRAM alias from 0x1000_0000 up to 0x1000_0000 + ALIAS_BYTES - 1 (ALIAS_BYTES defaults to 0x4000).
- R4: When a request lies outside its master's range, that master's `m_err` bit is high in the same cycle, the request is never granted, and that master's `m_ready` bit stays low.
- R5: When no data phase is pending, or the pending one completes in this cycle, the chosen eligible request drives `s_sel`=1, `s_addr`, `s_write` and `s_mid` (the master index) in the same cycle.
- R6: In the cycle after an address phase, if `s_ready` is high, `m_ready` is high for the granted master only.
- R7: While a data phase waits with `s_ready` low, `m_ready` is all zero, `s_sel` is low, and the owner is kept until `s_ready` rises.
- R8: Priority rotates. The search for the next grant starts at the master after the last one that completed. A master that owns the pending data phase is not granted again in that cycle. Under continuous requests, each grant therefore goes to the next requesting master in cyclic order 0,1,2,3.
- R9: Masters other than the data-phase owner always see ready low, and at most one `m_ready` bit is high.
- R10: In the cycle where a data phase completes, another eligible master's address phase is issued, with no idle cycle between.
- R11: After synchronous reset, `s_sel`, `m_ready` and `m_err` are all zero when no master requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_req | input | 4 | Request bit per master |
| m_addr | input | 128 | Addresses, master i in bits [32i+31:32i] |
| m_write | input | 4 | Write flag per master |
| m_ready | output | 4 | Transfer-complete strobe per master |
| m_err | output | 4 | Out-of-range request flag per master |
| s_sel | output | 1 | Address phase valid to slave |
| s_addr | output | 32 | Address routed to slave |
| s_write | output | 1 | Write flag routed to slave |
| s_mid | output | 2 | Index of the granted master |
| s_ready | input | 1 | Slave data-phase ready |

## Verification
The assertions assume that a master keeps its request and address stable until it sees its own ready, and drops an out-of-range request after seeing its error flag. They also assume that the slave's ready is meaningful only during a data phase.

The stimulus respects these assumptions. Inputs change only just after a clock edge. In the range sweep, each request is removed as soon as its address phase is seen. In the rotation runs, a master re-requests only after its data phase has completed.

// File: rtl/arb_pkg.sv
package arb_pkg;

    localparam int ADDR_W  = 32;
    localparam int NUM_M   = 4;
    localparam int MID_W   = $clog2(NUM_M);

    typedef enum logic [MID_W-1:0] {
        MST_IFETCH = 2'd0,
        MST_CDATA  = 2'd1,
        MST_SYS    = 2'd2,
        MST_DMA    = 2'd3
    } mst_e;

    localparam logic [ADDR_W-1:0] CODE_TOP  = 32'h1FFF_FFFF;
    localparam logic [ADDR_W-1:0] SYS_BASE  = 32'h2000_0000;
    localparam logic [ADDR_W-1:0] SYS_TOP   = 32'hDFFF_FFFF;
    localparam logic [ADDR_W-1:0] ALIAS_BASE = 32'h1000_0000;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              write;
    } aphase_t;

    function automatic logic addr_allowed(input mst_e mid,
                                          input logic [ADDR_W-1:0] a,
                                          input logic [ADDR_W-1:0] alias_bytes);
        logic in_alias;
        in_alias = (a >= ALIAS_BASE) && ((a - ALIAS_BASE) < alias_bytes);
        unique case (mid)
            MST_IFETCH, MST_CDATA: return a <= CODE_TOP;
            MST_SYS:               return (a >= SYS_BASE) && (a <= SYS_TOP);
            default:               return (a <= SYS_TOP) && !in_alias;
        endcase
    endfunction

endpackage

// File: rtl/arb_window_check.sv
module arb_window_check
    import arb_pkg::*;
#(
    parameter mst_e              MID         = MST_IFETCH,
    parameter logic [ADDR_W-1:0] ALIAS_BYTES = 32'h0000_4000
) (
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    output logic              eligible,
    output logic              err
);
    logic ok;
    always_comb begin
        ok       = addr_allowed(MID, addr, ALIAS_BYTES);
        eligible = req && ok;
        err      = req && !ok;
    end
endmodule

// File: rtl/arb_rr_picker.sv
module arb_rr_picker #(
    parameter int N     = 4,
    localparam int IDW  = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]   cand,
    input  logic [IDW-1:0] start,
    output logic           any,
    output logic [IDW-1:0] pick
);
    always_comb begin
        any  = 1'b0;
        pick = '0;
        for (int k = 0; k < N; k++) begin
            int idx;
            idx = (int'(start) + k) % N;
            if (!any && cand[idx]) begin
                any  = 1'b1;
                pick = IDW'(idx);
            end
        end
    end
endmodule

// File: rtl/bus_slave_rr_arb.sv
module bus_slave_rr_arb
    import arb_pkg::*;
#(
    parameter logic [ADDR_W-1:0] ALIAS_BYTES = 32'h0000_4000
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NUM_M-1:0]        m_req,
    input  logic [NUM_M*ADDR_W-1:0] m_addr,
    input  logic [NUM_M-1:0]        m_write,
    output logic [NUM_M-1:0]        m_ready,
    output logic [NUM_M-1:0]        m_err,
    output logic                    s_sel,
    output logic [ADDR_W-1:0]       s_addr,
    output logic                    s_write,
    output logic [MID_W-1:0]        s_mid,
    input  logic                    s_ready
);
    aphase_t            ap      [NUM_M];
    logic [NUM_M-1:0]   elig;
    logic [NUM_M-1:0]   cand;
    logic               any;
    logic [MID_W-1:0]   pick;

    logic               dp_valid;
    logic [MID_W-1:0]   dp_owner;
    logic [MID_W-1:0]   rr_ptr;
    logic               port_free;

    for (genvar i = 0; i < NUM_M; i++) begin : g_mst
        assign ap[i].addr  = m_addr[i*ADDR_W +: ADDR_W];
        assign ap[i].write = m_write[i];

        arb_window_check #(
            .MID         (mst_e'(i)),
            .ALIAS_BYTES (ALIAS_BYTES)
        ) u_win (
            .req      (m_req[i]),
            .addr     (ap[i].addr),
            .eligible (elig[i]),
            .err      (m_err[i])
        );

        assign cand[i]    = elig[i] && !(dp_valid && dp_owner == MID_W'(i));
        assign m_ready[i] = dp_valid && s_ready && dp_owner == MID_W'(i);
    end

    arb_rr_picker #(.N(NUM_M)) u_pick (
        .cand  (cand),
        .start (rr_ptr),
        .any   (any),
        .pick  (pick)
    );

    assign port_free = !dp_valid || s_ready;
    assign s_sel     = port_free && any;
    assign s_mid     = pick;
    assign s_addr    = s_sel ? ap[pick].addr  : '0;
    assign s_write   = s_sel ? ap[pick].write : 1'b0;

    always_ff @(posedge clk) begin
        if (rst) begin
            dp_valid <= 1'b0;
            dp_owner <= '0;
            rr_ptr   <= '0;
        end else begin
            if (port_free) begin
                dp_valid <= s_sel;
                dp_owner <= pick;
            end
            if (dp_valid && s_ready)
                rr_ptr <= MID_W'((int'(dp_owner) + 1) % NUM_M);
        end
    end

    // R9: a single completion strobe at a time
    a_r9_one_ready: assert property (@(posedge clk) disable iff (rst)
        $onehot0(m_ready));

    // R4: a flagged request never completes
    a_r4_err_not_ready: assert property (@(posedge clk) disable iff (rst)
        (m_err & m_ready) == '0);

    // R4: the slave only sees addresses its master may reach
    a_r4_sel_in_range: assert property (@(posedge clk) disable iff (rst)
        s_sel |-> !m_err[s_mid]);

    // R7: a waiting data phase blocks new address phases
    a_r7_no_issue_on_wait: assert property (@(posedge clk) disable iff (rst)
        (dp_valid && !s_ready) |-> !s_sel);

    // R7: owner held while waiting
    a_r7_owner_held: assert property (@(posedge clk) disable iff (rst)
        (dp_valid && !s_ready) |=> (dp_valid && $stable(dp_owner)));

    // R6: an issued address phase completes once the slave is ready
    a_r6_complete: assert property (@(posedge clk) disable iff (rst)
        s_sel |=> (!s_ready || m_ready != '0));
endmodule

// File: tb/bus_slave_rr_arb_bench.sv
module bus_slave_rr_arb_bench;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst;
    logic [3:0]   m_req;
    logic [127:0] m_addr;
    logic [3:0]   m_write;
    logic [3:0]   m_ready;
    logic [3:0]   m_err;
    logic         s_sel;
    logic [31:0]  s_addr;
    logic         s_write;
    logic [1:0]   s_mid;
    logic         s_ready;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_slave_rr_arb u_bus_slave_rr_arb (
        .clk(clk), .rst(rst), .m_req(m_req), .m_addr(m_addr),
        .m_write(m_write), .m_ready(m_ready), .m_err(m_err),
        .s_sel(s_sel), .s_addr(s_addr), .s_write(s_write),
        .s_mid(s_mid), .s_ready(s_ready)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit may_reach(input int m, input longint a);
        if (m < 2) return a < 64'h2000_0000;
        if (m == 2) return a >= 64'h2000_0000 && a < 64'hE000_0000;
        return a < 64'hE000_0000 && !(a >= 64'h1000_0000 && a < 64'h1000_4000);
    endfunction

    function automatic string tag_of(input int m);
        if (m < 2) return "R1";
        if (m == 2) return "R2";
        return "R3";
    endfunction

    task automatic to_sample; @(negedge clk); endtask
    task automatic to_drive;  @(posedge clk); #1; endtask

    task automatic set_addr(input int m, input logic [31:0] a);
        m_addr[m*32 +: 32] = a;
    endtask

    // rotation run: masters in set keep requesting; check cyclic order
    task automatic rr_run(input logic [3:0] set, input int cycles);
        int prev = -1;
        for (int m = 0; m < 4; m++) if (set[m])
            set_addr(m, (m == 2) ? 32'h2000_0040 : 32'h0000_0100 + 32'(m));
        m_req = set; s_ready = 1'b1;
        for (int c = 0; c < cycles; c++) begin
            to_sample();
            check("R9 ready count", $countones(m_ready) > 1, 0);
            if (prev >= 0) check("R6 owner completes", m_ready[prev], 1);
            check("R10 issue every cycle", s_sel, 1);
            if (prev >= 0) begin
                int exp = prev;
                for (int k = 1; k <= 4; k++)
                    if (set[(prev + k) % 4] && exp == prev) exp = (prev + k) % 4;
                check("R8 rotation", s_mid, exp);
            end
            prev = s_mid;
            to_drive();
        end
        m_req = '0;
        to_drive();
    endtask

    initial begin
        logic [31:0] pts [10];
        pts = '{32'h0, 32'h0FFF_FFFC, 32'h1000_0000, 32'h1000_3FFC, 32'h1000_4000,
                32'h1FFF_FFFC, 32'h2000_0000, 32'hDFFF_FFFC, 32'hE000_0000, 32'hFFFF_FFFC};
        rst = 1'b1; m_req = '0; m_addr = '0; m_write = '0; s_ready = 1'b1;
        repeat (3) to_drive();
        rst = 1'b0;
        to_sample();
        check("R11 s_sel", s_sel, 0);
        check("R11 m_ready", m_ready, 0);
        check("R11 m_err", m_err, 0);
        to_drive();

        // range sweep
        for (int m = 0; m < 4; m++) begin
            for (int p = 0; p < 10; p++) begin
                bit ok;
                ok = may_reach(m, pts[p]);
                set_addr(m, pts[p]); m_write[m] = p[0]; m_req = 4'b1 << m;
                to_sample();
                check({tag_of(m), " grant"}, s_sel, ok);
                check("R4 err flag", m_err[m], !ok);
                check("R4 no ready", m_ready, 0);
                if (ok) begin
                    check("R5 addr", s_addr, pts[p]);
                    check("R5 write", s_write, p[0]);
                    check("R5 id", s_mid, m);
                end
                to_drive();
                m_req = '0;
                to_sample();
                check("R6 ready", m_ready, ok ? (4'b1 << m) : 4'b0);
                to_drive();
            end
        end

        // slave wait states, then overlapped next address phase
        set_addr(2, 32'h2000_0100); m_write = 4'b0100; m_req = 4'b0100; s_ready = 1'b1;
        to_sample();
        check("R5 sys grant", s_sel, 1);
        to_drive();
        set_addr(0, 32'h0000_0200);
        m_req = 4'b0101; s_ready = 1'b0;
        for (int w = 0; w < 3; w++) begin
            to_sample();
            check("R7 no ready", m_ready, 0);
            check("R7 no issue", s_sel, 0);
            to_drive();
        end
        s_ready = 1'b1;
        to_sample();
        check("R9 owner only", m_ready, 4'b0100);
        check("R10 overlap issue", s_sel, 1);
        check("R10 next id", s_mid, 0);
        to_drive();
        m_req = '0; m_write = '0;
        to_sample();
        check("R6 second done", m_ready, 4'b0001);
        to_drive();

        rr_run(4'b1111, 16);
        rr_run(4'b1101, 12);
        rr_run(4'b1010, 8);
        rr_run(4'b0110, 8);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule